// File: doc/BRIEF.md
# Windowed Address Translation Map

This block turns a 12-bit offset, taken from a small window of a narrow 18-bit address space, into a full 32-bit address on a wider bus. It holds sixteen programmable entries. Each entry has a 32-bit base and a 5-bit control field. The top four offset bits choose the entry. The remaining eight bits are scaled down to the unit of the access and ORed into that entry's base. No adder is used, so each window spans 64 words of 32 bits, 128 half-words or 256 bytes on the wide bus.

Software programs the entries through a 16-bit register port. Each entry exposes three fields: the low half of the base, the high half of the base, and the control word. The translation path is purely combinational. Its address and control outputs follow the offset, the byte-access flag and the stored entries, and the bus sequencer that owns the handshakes consumes them.

Top module: `addr_window_map`

## Requirements
- R1: After reset, every base and control field reads back as zero. A byte access at any offset then translates to the offset's low eight bits, with the upper bits of the address zero.
- R2: Offset bits [11:8] select the entry whose base and control drive the outputs, and offset bits [7:0] form the in-window index.
- R3: When control bit 0 of the selected entry is 1 (32-bit mode) and `xl_byte_i` is 0, the address is the base ORed with the index shifted right by 2.
- R4: When control bit 0 of the selected entry is 0 (16-bit mode) and `xl_byte_i` is 0, the address is the base ORed with the index shifted right by 1.
- R5: When `xl_byte_i` is 1, the index is ORed into the base unshifted, whatever the entry's mode.
- R6: Base bits that overlap the index field are kept and ORed with the index, never added to it, and no error is indicated.
- R7: `cfg_addr_i[5:2]` names the entry and `cfg_addr_i[1:0]` the field: 0 is base[15:0], 1 is base[31:16], 2 is the control word in bits [4:0]. A write with `cfg_we_i` high takes effect at the next rising clock edge. Reads on `cfg_rdata_o` are combinational.
- R8: Field 3 always reads as zero, and writes to it change nothing. Control writes keep only data bits [4:0], and control reads return zero in bits [15:5].
- R9: `xl_ctrl_o` presents the five control bits of the selected entry: bit 0 is the 32-bit mode select, bit 1 the busy/empty interrupt enable, bit 2 the defer-interrupt-until-second-word option, and bits 3 and 4 are general.
- R10: A write to one entry leaves every other entry's base and control unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register port write strobe |
| cfg_addr_i | input | 6 | Entry in [5:2], field in [1:0] |
| cfg_wdata_i | input | 16 | Register port write data |
| cfg_rdata_o | output | 16 | Register port read data, combinational |
| xl_offset_i | input | 12 | In-window offset to translate |
| xl_byte_i | input | 1 | Byte access: no index scaling |
| xl_addr_o | output | 32 | Translated wide-bus address |
| xl_ctrl_o | output | 5 | Control bits of the selected entry |

## Verification
The assertions assume that the register port and the translation inputs change only between clock edges. The output-stability check also assumes that a quiet register port and a steady offset leave the translation unchanged. The bench drives every input on the falling edge. It holds the offset steady across idle cycles, and it issues writes only through a task that drops the strobe one cycle later. For the reserved field and the unaligned base, the bench writes real data and then reads the outcome back through the port and the translation outputs.

// File: rtl/awm_pkg.sv
package awm_pkg;
  typedef enum logic [1:0] {
    FLD_BASE_LO = 2'd0,
    FLD_BASE_HI = 2'd1,
    FLD_CTRL    = 2'd2,
    FLD_RSVD    = 2'd3
  } fld_e;

  localparam int unsigned CTRL_WIDE  = 0;
  localparam int unsigned CTRL_BEIRQ = 1;
  localparam int unsigned CTRL_DEFER = 2;
endpackage

// File: rtl/awm_regfile.sv
module awm_regfile
  import awm_pkg::*;
#(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned CTRL_W  = 5,
  localparam int unsigned SEL_W  = $clog2(N_ENTRY),
  localparam int unsigned PORT_W = BASE_W / 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                ent_i,
  input  fld_e                            fld_i,
  input  logic [PORT_W-1:0]               wdata_i,
  output logic [PORT_W-1:0]               rdata_o,
  output logic [N_ENTRY-1:0][BASE_W-1:0]  base_o,
  output logic [N_ENTRY-1:0][CTRL_W-1:0]  ctrl_o
);
  logic [N_ENTRY-1:0][BASE_W-1:0] base_q;
  logic [N_ENTRY-1:0][CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      for (int e = 0; e < N_ENTRY; e++) begin
        if (ent_i == SEL_W'(e)) begin
          unique case (fld_i)
            FLD_BASE_LO: base_q[e][PORT_W-1:0]      <= wdata_i;
            FLD_BASE_HI: base_q[e][BASE_W-1:PORT_W] <= wdata_i;
            FLD_CTRL:    ctrl_q[e]                  <= wdata_i[CTRL_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (fld_i)
      FLD_BASE_LO: rdata_o = base_q[ent_i][PORT_W-1:0];
      FLD_BASE_HI: rdata_o = base_q[ent_i][BASE_W-1:PORT_W];
      FLD_CTRL:    rdata_o = PORT_W'(ctrl_q[ent_i]);
      default:     rdata_o = '0;
    endcase
  end

  assign base_o = base_q;
  assign ctrl_o = ctrl_q;

  // write tracker for the checks below
  logic              wr_v_q;
  logic [SEL_W-1:0]  wr_ent_q;
  fld_e              wr_fld_q;
  logic [PORT_W-1:0] wr_dat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_v_q   <= 1'b0;
      wr_ent_q <= '0;
      wr_fld_q <= FLD_BASE_LO;
      wr_dat_q <= '0;
    end else begin
      wr_v_q   <= we_i;
      wr_ent_q <= ent_i;
      wr_fld_q <= fld_i;
      wr_dat_q <= wdata_i;
    end
  end

  p_wr_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_v_q && wr_fld_q == FLD_BASE_LO) |-> base_q[wr_ent_q][PORT_W-1:0] == wr_dat_q);
  p_wr_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_v_q && wr_fld_q == FLD_BASE_HI) |-> base_q[wr_ent_q][BASE_W-1:PORT_W] == wr_dat_q);
  p_wr_ctrl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_v_q && wr_fld_q == FLD_CTRL) |-> ctrl_q[wr_ent_q] == wr_dat_q[CTRL_W-1:0]);
  p_rsvd_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && fld_i == FLD_RSVD) |=> ($stable(base_q) && $stable(ctrl_q)));
endmodule

// File: rtl/awm_xlate.sv
module awm_xlate
  import awm_pkg::*;
#(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned CTRL_W  = 5,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned SEL_W  = $clog2(N_ENTRY),
  localparam int unsigned IDX_W  = OFF_W - SEL_W
) (
  input  logic [OFF_W-1:0]               offset_i,
  input  logic                           byte_i,
  input  logic [N_ENTRY-1:0][BASE_W-1:0] base_i,
  input  logic [N_ENTRY-1:0][CTRL_W-1:0] ctrl_i,
  output logic [BASE_W-1:0]              addr_o,
  output logic [CTRL_W-1:0]              ctrl_o,
  output logic [BASE_W-1:0]              sel_base_o
);
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx, idx_sh;

  assign sel    = offset_i[OFF_W-1:IDX_W];
  assign idx    = offset_i[IDX_W-1:0];
  assign ctrl_o = ctrl_i[sel];
  assign sel_base_o = base_i[sel];

  // scale to access unit: byte 0, half 1, word 2
  always_comb begin
    if (byte_i)                 idx_sh = idx;
    else if (ctrl_o[CTRL_WIDE]) idx_sh = idx >> 2;
    else                        idx_sh = idx >> 1;
  end

  assign addr_o = sel_base_o | BASE_W'(idx_sh);
endmodule

// File: rtl/addr_window_map.sv
module addr_window_map
  import awm_pkg::*;
#(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned CTRL_W  = 5,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned SEL_W  = $clog2(N_ENTRY),
  localparam int unsigned PORT_W = BASE_W / 2,
  localparam int unsigned CA_W   = SEL_W + 2,
  localparam int unsigned IDX_W  = OFF_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CA_W-1:0]   cfg_addr_i,
  input  logic [PORT_W-1:0] cfg_wdata_i,
  output logic [PORT_W-1:0] cfg_rdata_o,
  input  logic [OFF_W-1:0]  xl_offset_i,
  input  logic              xl_byte_i,
  output logic [BASE_W-1:0] xl_addr_o,
  output logic [CTRL_W-1:0] xl_ctrl_o
);
  logic [N_ENTRY-1:0][BASE_W-1:0] base_all;
  logic [N_ENTRY-1:0][CTRL_W-1:0] ctrl_all;
  logic [BASE_W-1:0]              sel_base;
  fld_e                           fld;

  assign fld = fld_e'(cfg_addr_i[1:0]);

  awm_regfile #(.N_ENTRY(N_ENTRY), .BASE_W(BASE_W), .CTRL_W(CTRL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .ent_i   (cfg_addr_i[CA_W-1:2]),
    .fld_i   (fld),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .base_o  (base_all),
    .ctrl_o  (ctrl_all)
  );

  awm_xlate #(.N_ENTRY(N_ENTRY), .BASE_W(BASE_W), .CTRL_W(CTRL_W), .OFF_W(OFF_W)) u_xlate (
    .offset_i   (xl_offset_i),
    .byte_i     (xl_byte_i),
    .base_i     (base_all),
    .ctrl_i     (ctrl_all),
    .addr_o     (xl_addr_o),
    .ctrl_o     (xl_ctrl_o),
    .sel_base_o (sel_base)
  );

  p_sel_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(xl_offset_i) && $stable(xl_byte_i) && !$past(cfg_we_i)) |-> $stable(xl_addr_o));
  p_base_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_addr_o & sel_base) == sel_base);
  p_wide_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_ctrl_o[CTRL_WIDE] && !xl_byte_i) |-> xl_addr_o[BASE_W-1:IDX_W-2] == sel_base[BASE_W-1:IDX_W-2]);
  p_half_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xl_ctrl_o[CTRL_WIDE] && !xl_byte_i) |-> xl_addr_o[BASE_W-1:IDX_W-1] == sel_base[BASE_W-1:IDX_W-1]);
  p_ctrl_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld == FLD_CTRL) |-> cfg_rdata_o[PORT_W-1:CTRL_W] == '0);
  p_rsvd_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld == FLD_RSVD) |-> cfg_rdata_o == '0);
endmodule

// File: tb/addr_window_map_test.sv
module addr_window_map_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [11:0] off = '0;
  logic        byte_acc = 1'b0;
  logic [31:0] addr;
  logic [4:0]  ctrl;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_window_map uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .xl_offset_i(off),
    .xl_byte_i(byte_acc), .xl_addr_o(addr), .xl_ctrl_o(ctrl)
  );

  typedef struct packed {
    logic [11:0] off;
    logic        byt;
    logic [31:0] exp_addr;
    logic [4:0]  exp_ctrl;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{12'h3FC, 1'b0, 32'h1234_563F, 5'h01, 8'd3},
    '{12'h300, 1'b0, 32'h1234_5600, 5'h01, 8'd3},
    '{12'h3FF, 1'b1, 32'h1234_56FF, 5'h01, 8'd5},
    '{12'h7FE, 1'b0, 32'hABCD_007F, 5'h06, 8'd4},
    '{12'h781, 1'b1, 32'hABCD_0081, 5'h06, 8'd5},
    '{12'hF10, 1'b0, 32'hFFFF_FF04, 5'h1F, 8'd9},
    '{12'h90F, 1'b0, 32'h0000_00F7, 5'h00, 8'd6},
    '{12'h91A, 1'b1, 32'h0000_00FA, 5'h00, 8'd6},
    '{12'h055, 1'b0, 32'h0000_002A, 5'h00, 8'd2},
    '{12'h8AA, 1'b0, 32'h0000_0055, 5'h00, 8'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ent, input logic [1:0] fld, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {ent, fld}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ent, input logic [1:0] fld, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = {ent, fld};
    #1 d = cfg_rdata;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(4'd5, 2'd0, d); chk("R1 base lo", 32'(d), 32'h0);
    rd(4'd5, 2'd1, d); chk("R1 base hi", 32'(d), 32'h0);
    rd(4'd5, 2'd2, d); chk("R1 ctrl", 32'(d), 32'h0);
    @(negedge clk); off = 12'h5AB; byte_acc = 1'b1;
    #1 chk("R1 xlate", addr, 32'h0000_00AB);
    // program entries (R7)
    wr(4'd3, 2'd0, 16'h5600); wr(4'd3, 2'd1, 16'h1234); wr(4'd3, 2'd2, 16'h0001);
    wr(4'd7, 2'd0, 16'h0000); wr(4'd7, 2'd1, 16'hABCD); wr(4'd7, 2'd2, 16'h0006);
    wr(4'd15, 2'd0, 16'hFF00); wr(4'd15, 2'd1, 16'hFFFF); wr(4'd15, 2'd2, 16'hFFFF);
    wr(4'd9, 2'd0, 16'h00F0);
    // table walk: R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      off = VEC[i].off; byte_acc = VEC[i].byt;
      #1;
      chk($sformatf("R%0d vec%0d addr", VEC[i].req, i), addr, VEC[i].exp_addr);
      chk($sformatf("R9 vec%0d ctrl", i), 32'(ctrl), 32'(VEC[i].exp_ctrl));
    end
    // R7 readback
    rd(4'd3, 2'd0, d); chk("R7 lo", 32'(d), 32'h5600);
    rd(4'd3, 2'd1, d); chk("R7 hi", 32'(d), 32'h1234);
    // R8: control keeps 5 bits
    rd(4'd15, 2'd2, d); chk("R8 ctrl mask", 32'(d), 32'h001F);
    // R8: reserved field write ignored
    wr(4'd3, 2'd3, 16'hFFFF);
    rd(4'd3, 2'd3, d); chk("R8 rsvd rd", 32'(d), 32'h0);
    rd(4'd3, 2'd2, d); chk("R8 ctrl kept", 32'(d), 32'h0001);
    @(negedge clk); off = 12'h3FC; byte_acc = 1'b0;
    #1 chk("R8 xlate kept", addr, 32'h1234_563F);
    // R10: neighbours untouched after write to entry 8
    wr(4'd8, 2'd1, 16'h7777);
    rd(4'd7, 2'd1, d); chk("R10 e7 hi", 32'(d), 32'hABCD);
    rd(4'd9, 2'd0, d); chk("R10 e9 lo", 32'(d), 32'h00F0);
    @(negedge clk); off = 12'h8AA; byte_acc = 1'b0;
    #1 chk("R10 e8 xlate", addr, 32'h7777_0055);
    // R5: byte override on a 32-bit entry
    @(negedge clk); off = 12'hFFF; byte_acc = 1'b1;
    #1 chk("R5 byte on wide", addr, 32'hFFFF_FFFF);
    // R1: reset clears programmed state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'd3, 2'd1, d); chk("R1 reset hi", 32'(d), 32'h0);
    done = 1'b1;
    summary();
  end
endmodule